// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the run of column addresses that the SDRAM sees for a read or write burst. A start strobe captures an 8-bit starting column, a 3-bit length code and an ordering bit. From the next cycle the block presents one column address per accepted beat on a valid/ready output stream, with a flag that marks the final beat.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that size. The upper column bits are held and only the low offset bits move, in either sequential or interleaved order. A full-page burst walks the whole 256-column row in sequential order and wraps at the row end. It keeps going until a terminate input marks the beat it is sampled on as the last. Requests with a code that is not supported get one illegal pulse and produce no beats.

Back-pressure rules: a beat is consumed on a clock edge where `col_valid_o` and `col_ready_i` are both high. While `col_valid_o` is high and `col_ready_i` is low, the address stays where it is and the burst does not advance. A full-page burst ends on the handshake of a beat during which `stop_i` is high. The stream never drops `col_valid_o` in the middle of a burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `col_valid_o`, `col_last_o` and `bad_req_o` are low.
- R2: Length codes 000, 001, 010 and 011 give bursts of exactly 1, 2, 4 and 8 handshaken beats. `col_last_o` is high only on the final beat, and `col_valid_o` is low in the cycle after the final handshake.
- R3: With `ilv_i`=0 and a fixed length N, beat k carries start[7:log2 N] unchanged in the upper bits and (start + k) mod N in the low log2 N bits, so the burst wraps inside its aligned block.
- R4: With `ilv_i`=1 and a fixed length N, beat k carries start[7:log2 N] unchanged in the upper bits and start XOR k in the low log2 N bits.
- R5: Code 111 with `ilv_i`=0 gives a full-page burst whose beat k is (start + k) mod 256. It runs past column 255 back to 0 and continues until a beat during which `stop_i` is high. `col_last_o` equals `stop_i` on every beat of such a burst, and the burst ends on that beat's handshake.
- R6: Codes 100, 101 and 110, and code 111 with `ilv_i`=1, are illegal. `bad_req_o` pulses high for exactly the one cycle after the start strobe, and no beat is produced.
- R7: While `col_valid_o`=1 and `col_ready_i`=0, `col_o` and `col_valid_o` hold their values and the beat index does not advance.
- R8: A start strobe that arrives while a burst is active is ignored. The running burst's address sequence and length are unchanged.
- R9: `col_valid_o` rises in the cycle after an accepted start strobe, and the first beat's address equals the captured `start_col_i`.
- R10: `stop_i` has no effect during a fixed-length burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request strobe, taken only while idle |
| start_col_i | input | 8 | Starting column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 sequential order, 1 interleaved order |
| stop_i | input | 1 | Ends a full-page burst on the current beat |
| col_ready_i | input | 1 | Consumer accepts the current beat |
| col_o | output | 8 | Column address of the current beat |
| col_valid_o | output | 1 | Current beat is valid |
| col_last_o | output | 1 | Current beat is the final beat |
| bad_req_o | output | 1 | One-cycle pulse for a rejected illegal request |

## Verification
The bench uses starting offsets in the middle of a block, so a design that carried into the next block instead of wrapping would produce upper column bits that change. It checks interleaved order at several start offsets, where a design that added instead of XORing would produce the wrong order. A full-page burst is started near column 255 to catch a missing row wrap. Back-pressure is applied at irregular points, where an address that moved while stalled would show up as a skipped beat. The bench also sends a second start in mid-burst, a terminate during fixed bursts, and every illegal code. A design that restarted, cut the burst short or emitted beats for these cases would be seen at the ports.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int COL_W = 8;
  localparam int LEN_W = 3;

  localparam logic [LEN_W-1:0] LEN_FULL = 3'b111;

  typedef struct packed {
    logic             legal;
    logic             full;
    logic [COL_W-1:0] mask;
  } burst_cfg_t;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int LW = LEN_W,
  parameter int MAX_FIXED_LOG = 3
) (
  input  logic [LW-1:0] code_i,
  input  logic          ilv_i,
  output logic          legal_o,
  output logic          full_o,
  output logic [CW-1:0] mask_o
);
  localparam logic [LW-1:0] FULL_CODE = {LW{1'b1}};

  logic [CW-1:0] fixed_mask;
  logic          is_fixed;

  assign is_fixed = (int'(code_i) <= MAX_FIXED_LOG);

  // Offset mask of a fixed burst: one bit set per doubling of length.
  for (genvar b = 0; b < CW; b++) begin : g_mask
    assign fixed_mask[b] = (b < int'(code_i));
  end

  always_comb begin
    legal_o = 1'b0;
    full_o  = 1'b0;
    mask_o  = '0;
    if (is_fixed) begin
      legal_o = 1'b1;
      mask_o  = fixed_mask;
    end else if (code_i == FULL_CODE && !ilv_i) begin
      legal_o = 1'b1;
      full_o  = 1'b1;
      mask_o  = {CW{1'b1}};
    end
  end
endmodule

// File: rtl/colgen_addr_order.sv
module colgen_addr_order
  import colgen_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] mask_i,
  input  logic [CW-1:0] beat_i,
  input  logic          ilv_i,
  output logic [CW-1:0] col_o
);
  logic [CW-1:0] sum;

  assign sum = base_i + beat_i;

  // Masked bits move with the beat; unmasked bits keep the block address.
  for (genvar i = 0; i < CW; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (ilv_i ? (base_i[i] ^ beat_i[i]) : sum[i])
                                : base_i[i];
  end
endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl
  import colgen_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] start_col_i,
  input  logic          ilv_i,
  input  logic          legal_i,
  input  logic          full_i,
  input  logic [CW-1:0] mask_i,
  input  logic          stop_i,
  input  logic          ready_i,
  output logic          busy_o,
  output logic          last_o,
  output logic          bad_o,
  output logic [CW-1:0] base_o,
  output logic [CW-1:0] mask_o,
  output logic [CW-1:0] beat_o,
  output logic          ilv_o
);
  burst_cfg_t    cfg_q;
  logic          busy_q, ilv_q, bad_q;
  logic [CW-1:0] base_q, beat_q;
  logic          accept, fire;

  assign accept = start_i && !busy_q && legal_i;
  assign fire   = busy_q && ready_i;
  assign last_o = busy_q && (cfg_q.full ? stop_i : (beat_q == cfg_q.mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bad_q  <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      ilv_q  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      bad_q <= start_i && !busy_q && !legal_i;
      if (accept) begin
        busy_q <= 1'b1;
        beat_q <= '0;
        base_q <= start_col_i;
        ilv_q  <= ilv_i;
        cfg_q  <= '{legal: 1'b1, full: full_i, mask: mask_i};
      end else if (fire) begin
        if (last_o) busy_q <= 1'b0;
        else        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign bad_o  = bad_q;
  assign base_o = base_q;
  assign mask_o = cfg_q.mask;
  assign beat_o = beat_q;
  assign ilv_o  = ilv_q;

  // R7: a stalled beat keeps its index
  assert_stall_holds_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !ready_i |=> busy_q && $stable(beat_q));
  // R6: a rejected request never opens a burst
  assert_bad_no_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_q && !legal_i |=> !busy_q && bad_q);
  // R10: fixed bursts end only when the index reaches the block size
  assert_fixed_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !cfg_q.full && fire && (beat_q != cfg_q.mask) |=> busy_q);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] start_col_i,
  input  logic [LW-1:0] len_code_i,
  input  logic          ilv_i,
  input  logic          stop_i,
  input  logic          col_ready_i,
  output logic [CW-1:0] col_o,
  output logic          col_valid_o,
  output logic          col_last_o,
  output logic          bad_req_o
);
  logic          dec_legal, dec_full;
  logic [CW-1:0] dec_mask;
  logic [CW-1:0] base, mask, beat;
  logic          ilv_run, busy;

  colgen_len_decode #(.CW(CW), .LW(LW)) u_dec (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .legal_o(dec_legal),
    .full_o (dec_full),
    .mask_o (dec_mask)
  );

  colgen_beat_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .ilv_i      (ilv_i),
    .legal_i    (dec_legal),
    .full_i     (dec_full),
    .mask_i     (dec_mask),
    .stop_i     (stop_i),
    .ready_i    (col_ready_i),
    .busy_o     (busy),
    .last_o     (col_last_o),
    .bad_o      (bad_req_o),
    .base_o     (base),
    .mask_o     (mask),
    .beat_o     (beat),
    .ilv_o      (ilv_run)
  );

  colgen_addr_order #(.CW(CW)) u_order (
    .base_i(base),
    .mask_i(mask),
    .beat_i(beat),
    .ilv_i (ilv_run),
    .col_o (col_o)
  );

  assign col_valid_o = busy;

  // R9: first beat carries the captured start column
  assert_first_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_valid_o) |-> col_o == $past(start_col_i));
  // R7: stalled output is held
  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && !col_ready_i |=> col_valid_o && $stable(col_o));
  // R2: stream closes right after the last handshake
  assert_close_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && col_ready_i && col_last_o |=> !col_valid_o);
  // R8: an open burst is not dropped or restarted by a new strobe
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && !(col_ready_i && col_last_o) |=> col_valid_o);
  // R3: successive beats of a burst use distinct columns
  assert_beats_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && col_ready_i && !col_last_o |=> col_o != $past(col_o));
  // R6: a rejection pulse never coincides with a beat
  assert_bad_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req_o |-> !col_valid_o);
endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       col_ready_i = 1'b0;
  logic [7:0] col_o;
  logic       col_valid_o, col_last_o, bad_req_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int exp_col(int st, int code, bit ilv, int k);
    int m;
    m = (code == 7) ? 255 : ((1 << code) - 1);
    if (ilv) return (st & ~m & 255) | ((st ^ k) & m);
    return (st & ~m & 255) | ((st + k) & m);
  endfunction

  // stall: 1 inserts back-pressure; stop_at: beat on which stop_i is raised;
  // stop_all: hold stop_i through a fixed burst; poke_at: beat with a second start
  task automatic run_burst(input string req, input int st, input int code, input bit ilv,
                           input bit stall, input int stop_at, input bit stop_all,
                           input int poke_at);
    int n, k, t;
    n = (code == 7) ? stop_at + 1 : (1 << code);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'(st); len_code_i = 3'(code); ilv_i = ilv;
    col_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    k = 0; t = 0;
    while (k < n) begin
      col_ready_i = stall ? ((t % 3) != 1) : 1'b1;
      stop_i      = stop_all || (code == 7 && k == stop_at);
      if (k == poke_at) begin
        start_i = 1'b1; start_col_i = 8'(st ^ 8'h55); len_code_i = 3'd0; ilv_i = ~ilv;
      end else start_i = 1'b0;
      #1;
      chk({req, " valid"}, int'(col_valid_o), 1);
      chk({req, " col"}, int'(col_o), exp_col(st, code, ilv, k));
      chk({req, " last"}, int'(col_last_o), int'(k == n - 1));
      if (col_ready_i) k++;
      t++;
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0; col_ready_i = 1'b0;
    #1;
    chk({req, " end valid"}, int'(col_valid_o), 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 valid", int'(col_valid_o), 0);
    chk("R1 last", int'(col_last_o), 0);
    chk("R1 bad", int'(bad_req_o), 0);
  endtask

  task automatic test_lengths();
    for (int c = 0; c < 4; c++) run_burst("R2 len", 8'h40 + c, c, 1'b0, 1'b0, 0, 1'b0, -1);
  endtask

  task automatic test_sequential();
    run_burst("R3 seq8", 8'h9D, 3, 1'b0, 1'b0, 0, 1'b0, -1);
    run_burst("R3 seq4", 8'h13, 2, 1'b0, 1'b0, 0, 1'b0, -1);
    run_burst("R3 seq2", 8'hFF, 1, 1'b0, 1'b0, 0, 1'b0, -1);
  endtask

  task automatic test_interleaved();
    run_burst("R4 ilv8", 8'h2B, 3, 1'b1, 1'b0, 0, 1'b0, -1);
    run_burst("R4 ilv8b", 8'hC6, 3, 1'b1, 1'b0, 0, 1'b0, -1);
    run_burst("R4 ilv4", 8'h71, 2, 1'b1, 1'b0, 0, 1'b0, -1);
  endtask

  task automatic test_full_page();
    run_burst("R5 page wrap", 8'hFA, 7, 1'b0, 1'b0, 11, 1'b0, -1);
    run_burst("R5 page first", 8'h20, 7, 1'b0, 1'b0, 0, 1'b0, -1);
    run_burst("R5 page long", 8'h03, 7, 1'b0, 1'b1, 300, 1'b0, -1);
  endtask

  task automatic test_illegal();
    int codes[4] = '{4, 5, 6, 7};
    foreach (codes[i]) begin
      @(negedge clk);
      start_i = 1'b1; start_col_i = 8'h10; len_code_i = 3'(codes[i]);
      ilv_i = (codes[i] == 7);
      @(negedge clk);
      start_i = 1'b0;
      #1;
      chk("R6 bad pulse", int'(bad_req_o), 1);
      chk("R6 no valid", int'(col_valid_o), 0);
      @(negedge clk);
      #1;
      chk("R6 bad clear", int'(bad_req_o), 0);
      chk("R6 still idle", int'(col_valid_o), 0);
    end
  endtask

  task automatic test_stall();
    run_burst("R7 stall seq", 8'hB5, 3, 1'b0, 1'b1, 0, 1'b0, -1);
    run_burst("R7 stall ilv", 8'h0E, 3, 1'b1, 1'b1, 0, 1'b0, -1);
  endtask

  task automatic test_busy_start();
    run_burst("R8 restart ignored", 8'h66, 3, 1'b0, 1'b0, 0, 1'b0, 2);
    run_burst("R8 restart stalled", 8'hE1, 2, 1'b1, 1'b1, 0, 1'b0, 1);
  endtask

  task automatic test_first_beat();
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'hA7; len_code_i = 3'd2; ilv_i = 1'b0;
    col_ready_i = 1'b0;
    #1;
    chk("R9 not yet valid", int'(col_valid_o), 0);
    @(negedge clk);
    start_i = 1'b0; start_col_i = 8'h00;
    #1;
    chk("R9 valid next cycle", int'(col_valid_o), 1);
    chk("R9 first col", int'(col_o), 8'hA7);
    col_ready_i = 1'b1;
    repeat (4) @(negedge clk);
    col_ready_i = 1'b0;
    #1;
    chk("R9 burst done", int'(col_valid_o), 0);
  endtask

  task automatic test_stop_fixed();
    run_burst("R10 stop in len8", 8'h58, 3, 1'b0, 1'b0, 0, 1'b1, -1);
    run_burst("R10 stop in len4", 8'h3A, 2, 1'b1, 1'b1, 0, 1'b1, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_lengths();
    test_sequential();
    test_interleaved();
    test_full_page();
    test_illegal();
    test_stall();
    test_busy_start();
    test_first_beat();
    test_stop_fixed();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule